// File: doc/BRIEF.md
# Strided Block Address Generator

This block turns a compact address-pattern description into the address sequence that one side (read or write) of a DMA transfer steps through. It takes a 32-bit base address with a 4-bit upper extension, a 32-bit pattern word and a total byte count. It then issues one beat at a time over a valid/ready handshake. Each beat carries the 36-bit address, the beat size in bytes, a last flag on the final beat and a burst hint.

The pattern has two levels. Inside a block, the address moves up, moves down or stays put by one beat size per beat. Once a block's worth of bytes has gone out, the next block starts at the previous block's start address plus the stride. A block size of zero turns the block level off. The block produces addresses only. Data movement, descriptor fetch and the bus protocol belong to its neighbours.

Top module: `strided_addr_gen`

## Requirements
- R1: After reset, `beat_valid`, `busy` and `done` are all 0.
- R2: Pattern word bits 31:30 set the beat size reported on `beat_size`: code 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, and 3 gives 8 bytes.
- R3: Pattern word bits 29:28 set the movement mode. Code 0 (ascending) adds the beat size to the address after each accepted beat inside a block.
- R4: Movement code 1 (descending) subtracts the beat size from the address after each accepted beat inside a block.
- R5: Movement code 2 (fixed) keeps the address unchanged from beat to beat inside a block.
- R6: Bits 27:14 hold the block size in bytes and bits 13:0 hold the stride in bytes. A beat that brings the bytes issued in the current block to at least the block size ends that block. The next beat's address is then the start address of that block plus the stride.
- R7: A block size of zero creates no block boundary, so the in-block pattern continues for the whole transfer.
- R8: Movement code 3 (burst) steps the address as in code 0. It also raises `beat_burst` on every beat that ends neither a block nor the transfer, and `beat_burst` is 0 in every other mode.
- R9: Each accepted beat takes one beat size from the remaining byte count. The beat issued while the remaining count is at most the beat size carries `beat_last` and is the final beat. `done` pulses for one cycle in the cycle after that beat is accepted.
- R10: A start with a total byte count of zero issues no beat and pulses `done` in the cycle after the start.
- R11: While `beat_valid` is 1 and `beat_ready` is 0, the address, size, last and burst outputs hold steady.
- R12: A `start` pulse while `busy` is 1 is ignored, and the running sequence continues unchanged.
- R13: The first address is {upper extension, base}, and all address arithmetic wraps modulo 2^36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the pattern and begin, taken only when idle |
| base_addr | input | 32 | Lower part of the first address |
| addr_ext | input | 4 | Upper extension of the first address |
| pattern_word | input | 32 | Size, movement, block size and stride fields |
| total_bytes | input | 22 | Bytes to cover in this transfer |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat is offered |
| beat_addr | output | 36 | Address of the offered beat |
| beat_size | output | 4 | Bytes in the offered beat (1, 2, 4 or 8) |
| beat_last | output | 1 | Offered beat is the final one |
| beat_burst | output | 1 | Burst-mode hint that more beats follow in this block |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
A start taken at a clock edge makes the first beat visible straight after that edge. A zero count instead raises `done` right after that edge. An accepted beat moves the address, the last flag and the burst flag to their next values at the same edge that accepts it. After the final beat, `done` is high for exactly the following cycle. The bench updates its behavioural model at each rising edge using the same handshake inputs the design sees. It then compares every output against the model at the falling edge, so every result is checked in the very cycle it falls due. Ready patterns of constant, alternating and pseudo-random stalls exercise the hold rule and the block turnover under back-pressure.

// File: rtl/sbag_pkg.sv
// Package: shared types and field positions for the strided block address
// generator. Field positions are fixed by the pattern-word format.
package sbag_pkg;

    // Movement codes, pattern word bits 29:28
    typedef enum logic [1:0] {
        MV_ASC   = 2'd0,
        MV_DESC  = 2'd1,
        MV_FIXED = 2'd2,
        MV_BURST = 2'd3
    } move_e;

    localparam int FIELD_W   = 14;   // block size and stride field width
    localparam int SIZE_W    = 4;    // beat size in bytes, max 8
    localparam int SZ_HI     = 31;
    localparam int SZ_LO     = 30;
    localparam int MV_HI     = 29;
    localparam int MV_LO     = 28;
    localparam int BLK_LO    = 14;
    localparam int STR_LO    = 0;

    // Decoded pattern configuration
    typedef struct packed {
        logic [SIZE_W-1:0]  size_bytes;
        move_e              mode;
        logic [FIELD_W-1:0] blk_size;
        logic [FIELD_W-1:0] stride;
    } pat_cfg_t;

endpackage

// File: rtl/sbag_decode.sv
// Module: sbag_decode
// Splits a 32-bit pattern word into beat size (bytes), movement mode, block
// size and stride. Purely combinational; assumes the fixed field layout.
module sbag_decode
    import sbag_pkg::*;
(
    input  logic [31:0] word_i,
    output pat_cfg_t    cfg_o
);

    // Decode every field of the pattern word
    always_comb begin
        cfg_o.size_bytes = SIZE_W'(1) << word_i[SZ_HI:SZ_LO];
        cfg_o.mode       = move_e'(word_i[MV_HI:MV_LO]);
        cfg_o.blk_size   = word_i[BLK_LO+FIELD_W-1:BLK_LO];
        cfg_o.stride     = word_i[STR_LO+FIELD_W-1:STR_LO];
    end

endmodule

// File: rtl/sbag_seq_ctrl.sv
// Module: sbag_seq_ctrl
// Sequencing state: run flag, remaining byte count, byte position inside the
// current block and the done pulse. Assumes cfg is stable while running
// (the top latches it on the accepted start).
module sbag_seq_ctrl
    import sbag_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   total_i,
    input  logic               ready_i,
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [FIELD_W-1:0] blk_i,
    output logic               load_o,
    output logic               adv_o,
    output logic               valid_o,
    output logic               last_o,
    output logic               blk_end_o,
    output logic               done_o
);

    localparam int POS_W = FIELD_W + 1;

    logic              run_q;
    logic              done_q;
    logic [CNT_W-1:0]  rem_q;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_next;

    // Handshake and boundary decode for the current beat
    always_comb begin
        load_o    = start_i && !run_q;
        adv_o     = run_q && ready_i;
        last_o    = run_q && (rem_q <= CNT_W'(size_i));
        pos_next  = pos_q + POS_W'(size_i);
        blk_end_o = run_q && (blk_i != '0) && (pos_next >= POS_W'(blk_i));
        valid_o   = run_q;
        done_o    = done_q;
    end

    // Run flag, counters and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            rem_q  <= '0;
            pos_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                pos_q <= '0;
                rem_q <= total_i;
                if (total_i == '0) begin
                    done_q <= 1'b1;
                end else begin
                    run_q <= 1'b1;
                end
            end else if (adv_o) begin
                if (last_o) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                    rem_q  <= '0;
                end else begin
                    rem_q <= rem_q - CNT_W'(size_i);
                    pos_q <= blk_end_o ? '0 : pos_next;
                end
            end
        end
    end

    // R10/R9: done never overlaps an offered beat
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);

    // R11: a stalled beat stays offered
    assert_hold_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o);

    // R9: accepting the last beat ends the run with a done pulse
    assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && last_o) |=> (!valid_o && done_o));

    // R12: a start while running does not restart the count
    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && start_i && !ready_i) |=> (valid_o && $stable(rem_q)));

endmodule

// File: rtl/sbag_addr_path.sv
// Module: sbag_addr_path
// Holds the current beat address and the start address of the current
// block. Steps the address by the movement mode within a block and jumps
// to block start plus stride at a block end. Wraps modulo 2^ADDR_W.
module sbag_addr_path
    import sbag_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [ADDR_W-1:0]  first_i,
    input  logic               adv_i,
    input  logic               valid_i,
    input  logic               last_i,
    input  logic               blk_end_i,
    input  pat_cfg_t           cfg_i,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] bstart_q;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] jump;

    // Next in-block address and next block start
    always_comb begin
        jump = bstart_q + ADDR_W'(cfg_i.stride);
        unique case (cfg_i.mode)
            MV_DESC:  step = addr_q - ADDR_W'(cfg_i.size_bytes);
            MV_FIXED: step = addr_q;
            default:  step = addr_q + ADDR_W'(cfg_i.size_bytes);
        endcase
    end

    // Address and block-start registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            bstart_q <= '0;
        end else if (load_i) begin
            addr_q   <= first_i;
            bstart_q <= first_i;
        end else if (adv_i && !last_i) begin
            if (blk_end_i) begin
                addr_q   <= jump;
                bstart_q <= jump;
            end else begin
                addr_q <= step;
            end
        end
    end

    assign addr_o = addr_q;

    // R11: the address holds while a beat is stalled
    assert_hold_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !adv_i) |=> $stable(addr_o));

    // R5: fixed mode keeps the address inside a block
    assert_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !last_i && !blk_end_i && cfg_i.mode == MV_FIXED) |=> $stable(addr_o));

    // R3: ascending mode moves up by the beat size inside a block
    assert_asc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !last_i && !blk_end_i && cfg_i.mode == MV_ASC)
        |=> (addr_o == $past(addr_o) + ADDR_W'(cfg_i.size_bytes)));

endmodule

// File: rtl/strided_addr_gen.sv
// Module: strided_addr_gen (top)
// Strided block address generator for one side of a DMA transfer. Latches
// the decoded pattern on an accepted start and offers one beat per cycle
// over valid/ready. Assumes start is ignored while busy.
module strided_addr_gen
    import sbag_pkg::*;
#(
    parameter int BASE_W = 32,
    parameter int EXT_W  = 4,
    parameter int CNT_W  = 22
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [BASE_W-1:0]         base_addr,
    input  logic [EXT_W-1:0]          addr_ext,
    input  logic [31:0]               pattern_word,
    input  logic [CNT_W-1:0]          total_bytes,
    input  logic                      beat_ready,
    output logic                      beat_valid,
    output logic [BASE_W+EXT_W-1:0]   beat_addr,
    output logic [SIZE_W-1:0]         beat_size,
    output logic                      beat_last,
    output logic                      beat_burst,
    output logic                      busy,
    output logic                      done
);

    localparam int ADDR_W = BASE_W + EXT_W;

    pat_cfg_t cfg_in;
    pat_cfg_t cfg_q;
    logic     load;
    logic     adv;
    logic     last;
    logic     blk_end;
    logic     valid;

    sbag_decode u_dec (
        .word_i (pattern_word),
        .cfg_o  (cfg_in)
    );

    // Pattern configuration register, loaded on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

    sbag_seq_ctrl #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .total_i   (total_bytes),
        .ready_i   (beat_ready),
        .size_i    (cfg_q.size_bytes),
        .blk_i     (cfg_q.blk_size),
        .load_o    (load),
        .adv_o     (adv),
        .valid_o   (valid),
        .last_o    (last),
        .blk_end_o (blk_end),
        .done_o    (done)
    );

    sbag_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .first_i   ({addr_ext, base_addr}),
        .adv_i     (adv),
        .valid_i   (valid),
        .last_i    (last),
        .blk_end_i (blk_end),
        .cfg_i     (cfg_q),
        .addr_o    (beat_addr)
    );

    // Beat outputs
    always_comb begin
        beat_valid = valid;
        busy       = valid;
        beat_size  = cfg_q.size_bytes;
        beat_last  = last;
        beat_burst = valid && (cfg_q.mode == MV_BURST) && !blk_end && !last;
    end

    // R8: burst hint only in burst mode and only with a beat offered
    assert_burst_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_burst |-> (beat_valid && cfg_q.mode == MV_BURST && !beat_last));

    // R2: offered beat size is a power of two no larger than 8
    assert_size_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ($countones(beat_size) == 1));

endmodule

// File: tb/sim_strided_addr_gen.sv
// Bench: behavioural per-cycle model compared with the design every cycle.
module sim_strided_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [3:0]  addr_ext = '0;
    logic [31:0] pattern_word = '0;
    logic [21:0] total_bytes = '0;
    logic        beat_ready = 1'b0;
    logic        beat_valid;
    logic [35:0] beat_addr;
    logic [3:0]  beat_size;
    logic        beat_last;
    logic        beat_burst;
    logic        busy;
    logic        done;

    always #5 clk = ~clk;

    strided_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .addr_ext(addr_ext), .pattern_word(pattern_word),
        .total_bytes(total_bytes), .beat_ready(beat_ready),
        .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_size(beat_size),
        .beat_last(beat_last), .beat_burst(beat_burst), .busy(busy), .done(done)
    );

    localparam longint MASK = (64'd1 << 36) - 1;

    int     n_cmp = 0;
    int     n_bad = 0;
    int     cycles = 0;
    string  cur_req = "R1";
    int     rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit     summary_done = 0;

    // model state
    bit     m_run = 0, m_done = 0;
    longint m_addr = 0, m_bstart = 0;
    int     m_rem = 0, m_pos = 0, m_size = 1, m_mode = 0, m_blk = 0, m_str = 0;
    int     m_beats = 0;

    function automatic bit m_last();
        return m_run && (m_rem <= m_size);
    endfunction
    function automatic bit m_bend();
        return m_run && (m_blk != 0) && (m_pos + m_size >= m_blk);
    endfunction

    // Model update at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_run = 0; m_done = 0; m_addr = 0; m_bstart = 0; m_rem = 0; m_pos = 0;
        end else begin
            bit l, b;
            l = m_last();
            b = m_bend();
            m_done = 0;
            if (start && !m_run) begin
                m_size = 1 << pattern_word[31:30];
                m_mode = int'(pattern_word[29:28]);
                m_blk  = int'(pattern_word[27:14]);
                m_str  = int'(pattern_word[13:0]);
                m_addr = longint'({addr_ext, base_addr});
                m_bstart = m_addr;
                m_rem = int'(total_bytes);
                m_pos = 0;
                if (total_bytes == 0) m_done = 1; else m_run = 1;
            end else if (m_run && beat_ready) begin
                m_beats++;
                if (l) begin
                    m_run = 0; m_done = 1; m_rem = 0;
                end else begin
                    m_rem -= m_size;
                    if (b) begin
                        m_bstart = (m_bstart + m_str) & MASK;
                        m_addr = m_bstart;
                        m_pos = 0;
                    end else begin
                        m_pos += m_size;
                        if (m_mode == 1) m_addr = (m_addr - m_size) & MASK;
                        else if (m_mode != 2) m_addr = (m_addr + m_size) & MASK;
                    end
                end
            end
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     cur_req, what, act, exp, cycles);
        end
    endtask

    // Compare every output against the model at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("valid", longint'(beat_valid), longint'(m_run));
            chk("busy", longint'(busy), longint'(m_run));
            chk("done", longint'(done), longint'(m_done));
            if (m_run) begin
                chk("addr", longint'(beat_addr), m_addr);
                chk("size", longint'(beat_size), longint'(m_size));
                chk("last", longint'(beat_last), longint'(m_last()));
                chk("burst", longint'(beat_burst),
                    longint'(m_mode == 3 && !m_bend() && !m_last()));
            end
        end
    end

    // Ready pattern, changed just after the falling edge
    always @(negedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: beat_ready <= 1'b1;
            1: beat_ready <= ~beat_ready;
            default: beat_ready <= lfsr[0];
        endcase
    end

    function automatic logic [31:0] pw(input int sz, input int mv, input int blk, input int str);
        return {sz[1:0], mv[1:0], blk[13:0], str[13:0]};
    endfunction

    task automatic report();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    endtask

    task automatic run(input string req, input logic [3:0] ext, input logic [31:0] base,
                       input logic [31:0] word, input int total, input int rmode,
                       input int exp_beats, input bit poke);
        int b0;
        cur_req = req;
        rdy_mode = rmode;
        @(negedge clk); #2;
        b0 = m_beats;
        addr_ext = ext; base_addr = base; pattern_word = word;
        total_bytes = 22'(total); start = 1'b1;
        @(negedge clk); #2;
        start = 1'b0;
        if (poke) begin
            // R12: new start with other values while busy
            repeat (3) @(negedge clk);
            #2;
            addr_ext = 4'h5; base_addr = 32'h0BAD0000; pattern_word = pw(0, 2, 0, 0);
            total_bytes = 22'd3; start = 1'b1;
            @(negedge clk); #2;
            start = 1'b0;
        end
        while (m_run) @(negedge clk);
        repeat (3) @(negedge clk);
        // beat count computed from the requirement, tagged with this test
        n_cmp++;
        if (m_beats - b0 != exp_beats) begin
            n_bad++;
            $display("FAIL %s beat count: actual %0d expected %0d", req, m_beats - b0, exp_beats);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        chk("reset valid", longint'(beat_valid), 0);
        chk("reset busy", longint'(busy), 0);
        chk("reset done", longint'(done), 0);
        #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run("R3", 4'h0, 32'h0000_1000, pw(2, 0, 0, 0), 32, 0, 8, 0);
        run("R2", 4'h0, 32'h0000_2000, pw(0, 0, 0, 0), 5, 2, 5, 0);
        run("R4", 4'h1, 32'h0000_3000, pw(1, 1, 0, 0), 12, 0, 6, 0);
        run("R5", 4'h0, 32'h0000_4004, pw(0, 2, 0, 0), 6, 1, 6, 0);
        run("R6", 4'h0, 32'h0001_0000, pw(2, 0, 16, 256), 64, 1, 16, 0);
        run("R7", 4'h0, 32'h0002_0000, pw(2, 1, 0, 1000), 40, 2, 10, 0);
        run("R8", 4'h0, 32'h0003_0000, pw(2, 3, 8, 64), 32, 0, 8, 0);
        run("R8", 4'h0, 32'h0003_8000, pw(1, 3, 0, 0), 8, 2, 4, 0);
        run("R9", 4'h0, 32'h0004_0000, pw(2, 0, 0, 0), 10, 0, 3, 0);
        run("R10", 4'h0, 32'h0005_0000, pw(2, 0, 0, 0), 0, 0, 0, 0);
        run("R11", 4'h0, 32'h0006_0000, pw(3, 2, 24, 40), 96, 2, 12, 0);
        run("R12", 4'h0, 32'h0007_0000, pw(2, 0, 0, 0), 40, 1, 10, 1);
        run("R13", 4'hF, 32'hFFFF_FFF8, pw(3, 0, 0, 0), 24, 0, 3, 0);
        run("R6", 4'h2, 32'h0008_0100, pw(3, 1, 16, 8), 64, 2, 8, 0);
        run("R5", 4'h0, 32'h0009_0000, pw(0, 2, 4, 16), 12, 0, 12, 0);
        report();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule